// File: doc/BRIEF.md
# Carrier Phase-Switching Channel Encoder

This block generates the primary-side drive for a gate driver that uses magnetic isolation for a three-level bridge leg. A master clock running at twice the carrier frequency is divided by a toggling register into a carrier with exactly 50% duty cycle, which is nominally 1 MHz. The carrier and its complement drive every power transformer directly. Each shared signal transformer serves two devices. The channel is idle when neither of its devices is commanded. When a device is commanded, the channel carries the same carrier, and its phase relative to the power carrier tells the secondary side which of the two devices to switch on.

Channel 0 serves the outer and inner devices of the high side. Channel 1 serves the inner and outer devices of the low side. The commanded outer device is sent in phase with the power carrier. The commanded inner device is sent in anti-phase. The outer device takes priority if both commands of a channel are active. Commands are sampled only once per carrier period, so every transformer primary sees only whole carrier periods.

Top module: `carrier_phase_enc`

## Requirements
- R1: Every power true output toggles on every clock edge after reset, giving a carrier at half the clock rate with 50% duty cycle.
- R2: Each power pair is complementary after the first clock edge following reset release, and all power pairs carry identical values.
- R3: While rst_ni is low, all outputs are low. The first clock edge after release starts a carrier period, with the power true output low.
- R4: A channel with neither command active holds both of its drive outputs low, and never drives both high at once.
- R5: A channel whose outer command (outer_en_i bit c) is active drives its true output equal to the power true output (in phase).
- R6: A channel whose only active command is its inner command (inner_en_i bit c) drives its true output equal to the power complement output (anti-phase).
- R7: When both commands of a channel are active, the channel uses the outer (in-phase) encoding.
- R8: Commands are sampled only at the edge where the power true output falls, which is a period boundary. A change at any other edge takes effect at the next boundary, and within a period the second half of each drive pair is the inverse of the first half.
- R9: The channels are independent. Bit 0 of each command vector belongs to the high-side channel, and bit 1 belongs to the low-side channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock at twice the carrier frequency |
| rst_ni | input | 1 | Asynchronous active-low reset |
| outer_en_i | input | NUM_CH | Outer-device command per channel |
| inner_en_i | input | NUM_CH | Inner-device command per channel |
| pwr_p_o | output | NUM_PWR | Power transformer drive, true phase |
| pwr_n_o | output | NUM_PWR | Power transformer drive, complement phase |
| sig_p_o | output | NUM_CH | Signal transformer drive, true side |
| sig_n_o | output | NUM_CH | Signal transformer drive, complement side |

## Verification
A command change and a carrier period boundary can fall in the same clock edge. The two possible outcomes differ: either the new encoding starts immediately, or the old period has to finish first. The bench locks onto the carrier by watching the power output. It then applies commands in the cycle just before a boundary and expects the new phase on the next edge. It also changes commands in the middle of a period and expects the old phase for the remaining half, with the new one appearing only after the following boundary. A second coincidence, both commands of one channel active together, is driven directly, and the bench expects the in-phase encoding.

// File: rtl/carrier_phase_pkg.sv
package carrier_phase_pkg;

  typedef struct packed {
    logic en;
    logic inv;
  } chan_cfg_t;

  // outer device wins; outer = in phase, inner = anti-phase
  function automatic chan_cfg_t pick_cfg(input logic outer, input logic inner);
    chan_cfg_t c;
    c.en  = outer | inner;
    c.inv = ~outer & inner;
    return c;
  endfunction

endpackage

// File: rtl/carrier_div.sv
module carrier_div (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bnd_o,
  output logic nxt_phase_o
);
  logic phase_q;

  // reset to last half so the first edge opens a period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b1;
    else         phase_q <= ~phase_q;
  end

  assign bnd_o       = phase_q;
  assign nxt_phase_o = ~phase_q;
endmodule

// File: rtl/chan_latch.sv
module chan_latch
  import carrier_phase_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      bnd_i,
  input  logic      outer_i,
  input  logic      inner_i,
  output chan_cfg_t cfg_nxt_o
);
  chan_cfg_t cfg_q;
  chan_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (bnd_i) cfg_d = pick_cfg(outer_i, inner_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign cfg_nxt_o = cfg_d;
endmodule

// File: rtl/drive_reg.sv
module drive_reg
  import carrier_phase_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int NUM_PWR = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    nxt_phase_i,
  input  chan_cfg_t [NUM_CH-1:0]  cfg_nxt_i,
  output logic [NUM_PWR-1:0]      pwr_p_o,
  output logic [NUM_PWR-1:0]      pwr_n_o,
  output logic [NUM_CH-1:0]       sig_p_o,
  output logic [NUM_CH-1:0]       sig_n_o
);
  for (genvar p = 0; p < NUM_PWR; p++) begin : g_pwr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pwr_p_o[p] <= 1'b0;
        pwr_n_o[p] <= 1'b0;
      end else begin
        pwr_p_o[p] <= nxt_phase_i;
        pwr_n_o[p] <= ~nxt_phase_i;
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sig
    logic ph;
    assign ph = nxt_phase_i ^ cfg_nxt_i[c].inv;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sig_p_o[c] <= 1'b0;
        sig_n_o[c] <= 1'b0;
      end else begin
        sig_p_o[c] <= cfg_nxt_i[c].en & ph;
        sig_n_o[c] <= cfg_nxt_i[c].en & ~ph;
      end
    end
  end
endmodule

// File: rtl/carrier_phase_enc.sv
module carrier_phase_enc
  import carrier_phase_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int NUM_PWR = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CH-1:0]  outer_en_i,
  input  logic [NUM_CH-1:0]  inner_en_i,
  output logic [NUM_PWR-1:0] pwr_p_o,
  output logic [NUM_PWR-1:0] pwr_n_o,
  output logic [NUM_CH-1:0]  sig_p_o,
  output logic [NUM_CH-1:0]  sig_n_o
);
  logic                  bnd;
  logic                  nxt_phase;
  chan_cfg_t [NUM_CH-1:0] cfg_nxt;

  carrier_div u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bnd_o       (bnd),
    .nxt_phase_o (nxt_phase)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_latch u_latch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .bnd_i     (bnd),
      .outer_i   (outer_en_i[c]),
      .inner_i   (inner_en_i[c]),
      .cfg_nxt_o (cfg_nxt[c])
    );
  end

  drive_reg #(.NUM_CH(NUM_CH), .NUM_PWR(NUM_PWR)) u_drv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nxt_phase_i (nxt_phase),
    .cfg_nxt_i   (cfg_nxt),
    .pwr_p_o     (pwr_p_o),
    .pwr_n_o     (pwr_n_o),
    .sig_p_o     (sig_p_o),
    .sig_n_o     (sig_n_o)
  );
endmodule

// File: rtl/carrier_phase_enc_chk.sv
module carrier_phase_enc_chk #(
  parameter int NUM_CH  = 2,
  parameter int NUM_PWR = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_PWR-1:0] pwr_p_o,
  input logic [NUM_PWR-1:0] pwr_n_o,
  input logic [NUM_CH-1:0]  sig_p_o,
  input logic [NUM_CH-1:0]  sig_n_o
);
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni)
      AST_RESET_QUIET: assert ((pwr_p_o | pwr_n_o) == '0 && (sig_p_o | sig_n_o) == '0); // R3
  end

  AST_PWR_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |=> pwr_p_o[0] != $past(pwr_p_o[0])); // R1

  AST_PWR_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> ((pwr_p_o ^ pwr_n_o) == '1) && ($countones(pwr_p_o) == 0 || pwr_p_o == '1)); // R2

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    AST_SIG_NOT_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sig_p_o[c] && sig_n_o[c])); // R4

    AST_WHOLE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (started_q && !pwr_p_o[0]) |=>
        (sig_p_o[c] == $past(sig_n_o[c])) && (sig_n_o[c] == $past(sig_p_o[c]))); // R8
  end
endmodule

bind carrier_phase_enc carrier_phase_enc_chk #(.NUM_CH(NUM_CH), .NUM_PWR(NUM_PWR)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pwr_p_o (pwr_p_o),
  .pwr_n_o (pwr_n_o),
  .sig_p_o (sig_p_o),
  .sig_n_o (sig_n_o)
);

// File: tb/carrier_phase_enc_tb.sv
module carrier_phase_enc_tb;
  localparam int NUM_CH  = 2;
  localparam int NUM_PWR = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NUM_CH-1:0]  outer_en = '0;
  logic [NUM_CH-1:0]  inner_en = '0;
  logic [NUM_PWR-1:0] pwr_p, pwr_n;
  logic [NUM_CH-1:0]  sig_p, sig_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  carrier_phase_enc #(.NUM_CH(NUM_CH), .NUM_PWR(NUM_PWR)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .outer_en_i(outer_en), .inner_en_i(inner_en),
    .pwr_p_o(pwr_p), .pwr_n_o(pwr_n), .sig_p_o(sig_p), .sig_n_o(sig_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // expected {sig_p, sig_n} per channel for power true level v
  function automatic logic [3:0] exp_sig(input logic v, input logic [1:0] o, input logic [1:0] i);
    logic [1:0] ep, en;
    for (int c = 0; c < 2; c++) begin
      logic act, inv;
      act = o[c] | i[c];
      inv = ~o[c] & i[c];
      ep[c] = act & (v ^ inv);
      en[c] = act & ~(v ^ inv);
    end
    return {ep, en};
  endfunction

  // stop at a negedge whose next posedge is a period boundary
  task automatic align();
    @(negedge clk);
    while (pwr_p[0] !== 1'b1) @(negedge clk);
  endtask

  task automatic t_reset();
    outer_en = 2'b01; inner_en = 2'b10;
    repeat (3) @(negedge clk);
    chk("R3 reset quiet", {pwr_p, pwr_n, sig_p, sig_n}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R3 first half power", {6'd0, pwr_p[0], pwr_n[0]}, 8'b01);
    chk("R3 first period sampled", {4'd0, sig_p, sig_n}, {4'd0, exp_sig(1'b0, 2'b01, 2'b10)});
  endtask

  task automatic t_power();
    for (int k = 0; k < 8; k++) begin
      logic [NUM_PWR-1:0] prev;
      prev = pwr_p;
      @(negedge clk);
      chk("R1 toggle", {6'd0, pwr_p}, {6'd0, ~prev});
      chk("R2 complement", {6'd0, pwr_p ^ pwr_n}, 8'h03);
      chk("R2 pairs equal", {7'd0, pwr_p[0] ^ pwr_p[1]}, 8'h00);
    end
  endtask

  task automatic t_period(input string req, input logic [1:0] o, input logic [1:0] i);
    align();
    outer_en = o; inner_en = i;
    @(negedge clk);
    chk(req, {pwr_p[0], 3'd0, sig_p, sig_n}, {1'b0, 3'd0, exp_sig(1'b0, o, i)});
    @(negedge clk);
    chk(req, {pwr_p[0], 3'd0, sig_p, sig_n}, {1'b1, 3'd0, exp_sig(1'b1, o, i)});
  endtask

  task automatic t_midchange();
    align();
    outer_en = 2'b01; inner_en = 2'b00;
    @(negedge clk);
    chk("R8 start A", {4'd0, sig_p, sig_n}, {4'd0, exp_sig(1'b0, 2'b01, 2'b00)});
    outer_en = 2'b00; inner_en = 2'b11;  // mid-period change
    @(negedge clk);
    chk("R8 held mid-period", {4'd0, sig_p, sig_n}, {4'd0, exp_sig(1'b1, 2'b01, 2'b00)});
    @(negedge clk);
    chk("R8 applied at boundary", {4'd0, sig_p, sig_n}, {4'd0, exp_sig(1'b0, 2'b00, 2'b11)});
    @(negedge clk);
    chk("R8 second half", {4'd0, sig_p, sig_n}, {4'd0, exp_sig(1'b1, 2'b00, 2'b11)});
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_power();
    t_period("R4 idle", 2'b00, 2'b00);
    t_period("R5 outer in phase", 2'b11, 2'b00);
    t_period("R6 inner anti-phase", 2'b00, 2'b11);
    t_period("R7 both outer wins", 2'b11, 2'b11);
    t_period("R9 independent ch0 outer ch1 inner", 2'b01, 2'b10);
    t_period("R9 independent ch0 inner ch1 idle", 2'b00, 2'b01);
    t_midchange();
    t_period("R4 idle after activity", 2'b00, 2'b00);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule